// File: doc/BRIEF.md
# PCI Address Window Translator

This block sits between a local request port and a PCI master engine. It claims local reads and writes whose address lies in a fixed 1 GB window and turns each one into a single PCI bus request: a bus address, a four-bit PCI command code and byte enables. A mode input moves the whole window between memory cycles and Type-0 configuration cycles. In memory mode, the bus address is the low 30 bits of the local address with two programmable upper bits placed above them. In configuration mode, the local address carries a device number, a function number and a register offset. From these the block builds a configuration address with a one-hot IDSEL line.

The block checks each request against the access-size rules and, in configuration mode, against the reachable devices. A request that fails a check gets an error response and produces no bus traffic. Sub-word configuration writes become a read of the containing dword, followed by a write of the merged dword. Read data is returned right-aligned and masked to the access size. A bus abort ends the access with an error and all-ones read data. One request is in flight at a time.

Top module: `pci_win_xlat`

## Requirements
- R1: Only local addresses with bits 31:30 equal to 2'b10 (0x80000000 to 0xBFFFFFFF) are claimed. Any other request produces no bus request and no response, and `req_ready` stays high.
- R2: In memory mode (`cfg_mode`=0), the bus address is {`mem_upper`, local address bits 29:2, 2'b00}. The command is 4'h6 for a read and 4'h7 for a write.
- R3: The level of `cfg_mode` in the accepting cycle picks the cycle type. In configuration mode, reads and the read phase of writes use command 4'hA, and the write phase uses 4'hB.
- R4: In configuration mode, the local address bits are decoded as follows: device in bits 15:11, function in bits 10:8, register offset in bits 7:0. The bus address is (1 << (13+device)) | (function << 8) | (offset with bits 1:0 cleared).
- R5: A configuration request is rejected with an error response and no bus request in any of these cases:
  - the device number is above 18,
  - the formed address is at or above 0x00100000,
  - the device number is 3 (the host bridge's own slot).
- R6: `req_size` must be 1, 2 or 4, and offset bits 1:0 plus the size must not exceed 4. Otherwise the request gets an error response and no bus request. Memory cycles enable byte lanes offset through offset+size-1 (bit i is lane i). Configuration cycles enable all four lanes.
- R7: On a successful read, `rsp_rdata` = (bus dword >> 8×offset[1:0]) masked to the low 8×size bits. On a successful write, it is zero.
- R8: A memory write places the write data shifted left by 8×offset[1:0]. A configuration write first reads the dword, then writes (read & ~(mask << sh)) | ((wdata & mask) << sh), where mask covers 8×size bits and sh = 8×offset[1:0].
- R9: If `pci_abort` is high with `pci_done`, the response has `rsp_err`=1 and `rsp_rdata`=0xFFFFFFFF. If the abort comes in the read phase of a configuration write, no write phase follows.
- R10: `pci_valid` stays high with stable address, command, byte enables and write data until the cycle in which `pci_ready` is sampled high, and it falls in the following cycle.
- R11: `req_ready` falls in the cycle after an in-window acceptance and returns one cycle after `rsp_valid`. `rsp_valid` lasts exactly one cycle. A rejected request responds in the cycle after acceptance.
- R12: During and right after reset, `req_ready`=1, `pci_valid`=0 and `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Local request strobe, taken when `req_ready` is high |
| req_ready | output | 1 | Block idle and able to accept |
| req_addr | input | 32 | Local byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 3 | Access size in bytes (1, 2 or 4) |
| req_wdata | input | 32 | Write data, right-aligned |
| cfg_mode | input | 1 | 1 = configuration cycles, 0 = memory cycles |
| mem_upper | input | 2 | Upper two bus address bits for memory cycles |
| pci_valid | output | 1 | Bus request valid |
| pci_ready | input | 1 | Engine takes the bus request |
| pci_addr | output | 32 | Bus address |
| pci_cmd | output | 4 | PCI command code |
| pci_be | output | 4 | Byte lane enables, active high |
| pci_wdata | output | 32 | Lane-placed write data |
| pci_done | input | 1 | Engine completion, only after the request was taken |
| pci_abort | input | 1 | Completion ended in a bus abort |
| pci_rdata | input | 32 | Dword read from the bus |
| rsp_valid | output | 1 | Local response strobe |
| rsp_err | output | 1 | Request rejected or aborted |
| rsp_rdata | output | 32 | Right-aligned read data |

## Verification
The bench builds the block with its default parameters: IDSEL base at bit 13, a 1 MB configuration span and a highest device number of 18. With these values the span limit cuts in at device 7, well below the device-number limit. Devices 0 to 6 except slot 3 therefore reach the bus, and devices 7, 19 and 31 exercise both rejection paths. The bench's engine model varies its acceptance latency, so requests are held across several cycles. It can inject an abort on a chosen bus transaction, which reaches both the single-phase path and the read phase of a read-modify-write.

// File: rtl/pci_win_xlat.sv
module pci_win_xlat #(
  parameter int IDSEL_LSB     = 13,
  parameter int CFG_SPAN_LOG2 = 20,
  parameter int MAX_DEV       = 18,
  parameter int HOST_SLOT     = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  input  logic        req_write,
  input  logic [2:0]  req_size,
  input  logic [31:0] req_wdata,
  input  logic        cfg_mode,
  input  logic [1:0]  mem_upper,
  output logic        pci_valid,
  input  logic        pci_ready,
  output logic [31:0] pci_addr,
  output logic [3:0]  pci_cmd,
  output logic [3:0]  pci_be,
  output logic [31:0] pci_wdata,
  input  logic        pci_done,
  input  logic        pci_abort,
  input  logic [31:0] pci_rdata,
  output logic        rsp_valid,
  output logic        rsp_err,
  output logic [31:0] rsp_rdata
);

  localparam logic [3:0]  CMD_MRD   = 4'h6;
  localparam logic [3:0]  CMD_MWR   = 4'h7;
  localparam logic [3:0]  CMD_CRD   = 4'hA;
  localparam logic [3:0]  CMD_CWR   = 4'hB;
  localparam logic [4:0]  MAX_DEV_V = 5'(MAX_DEV);
  localparam logic [4:0]  HOST_V    = 5'(HOST_SLOT);
  localparam logic [63:0] CFG_LIMIT = 64'd1 << CFG_SPAN_LOG2;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_RSP} st_t;
  st_t st;

  wire       in_win = (req_addr[31:30] == 2'b10);
  wire [1:0] off    = req_addr[1:0];
  wire [4:0] dev    = req_addr[15:11];
  wire [2:0] fn     = req_addr[10:8];
  wire [4:0] sh     = {off, 3'b000};

  wire       size_ok = (req_size == 3'd1) || (req_size == 3'd2) || (req_size == 3'd4);
  wire [3:0] span    = {2'b00, off} + {1'b0, req_size};
  wire       fits    = (span <= 4'd4);

  logic [3:0]  be_base;
  logic [31:0] dmask;
  always_comb begin
    case (req_size)
      3'd1:    begin be_base = 4'b0001; dmask = 32'h0000_00FF; end
      3'd2:    begin be_base = 4'b0011; dmask = 32'h0000_FFFF; end
      default: begin be_base = 4'b1111; dmask = 32'hFFFF_FFFF; end
    endcase
  end
  wire [3:0] be_lane = be_base << off;

  wire [5:0]  idsel_pos = 6'(IDSEL_LSB) + {1'b0, dev};
  wire [63:0] cfg_full  = (64'd1 << idsel_pos) | {53'd0, fn, req_addr[7:2], 2'b00};
  wire        cfg_bad   = (dev > MAX_DEV_V) || (cfg_full >= CFG_LIMIT) || (dev == HOST_V);
  wire        reject    = !size_ok || !fits || (cfg_mode && cfg_bad);

  logic [1:0]  r_off;
  logic [31:0] r_mask, r_wdata;
  logic        r_write, r_rmw;
  wire  [4:0]  r_sh   = {r_off, 3'b000};
  wire  [31:0] merged = (pci_rdata & ~(r_mask << r_sh)) | ((r_wdata & r_mask) << r_sh);

  assign req_ready = (st == S_IDLE);
  assign pci_valid = (st == S_ISSUE);
  assign rsp_valid = (st == S_RSP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      pci_addr  <= '0;
      pci_cmd   <= '0;
      pci_be    <= '0;
      pci_wdata <= '0;
      r_off     <= '0;
      r_mask    <= '0;
      r_wdata   <= '0;
      r_write   <= 1'b0;
      r_rmw     <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid && in_win) begin
          r_off   <= off;
          r_mask  <= dmask;
          r_wdata <= req_wdata;
          r_write <= req_write;
          if (reject) begin
            rsp_err   <= 1'b1;
            rsp_rdata <= '1;
            st        <= S_RSP;
          end else begin
            rsp_err <= 1'b0;
            st      <= S_ISSUE;
            if (cfg_mode) begin
              pci_addr  <= cfg_full[31:0];
              pci_cmd   <= CMD_CRD;
              pci_be    <= 4'hF;
              pci_wdata <= '0;
              r_rmw     <= req_write;
            end else begin
              pci_addr  <= {mem_upper, req_addr[29:2], 2'b00};
              pci_cmd   <= req_write ? CMD_MWR : CMD_MRD;
              pci_be    <= be_lane;
              pci_wdata <= req_wdata << sh;
              r_rmw     <= 1'b0;
            end
          end
        end
        S_ISSUE: if (pci_ready) st <= S_WAIT;
        S_WAIT: if (pci_done) begin
          if (pci_abort) begin
            rsp_err   <= 1'b1;
            rsp_rdata <= '1;
            r_rmw     <= 1'b0;
            st        <= S_RSP;
          end else if (r_rmw) begin
            r_rmw     <= 1'b0;
            pci_cmd   <= CMD_CWR;
            pci_wdata <= merged;
            st        <= S_ISSUE;
          end else begin
            rsp_err   <= 1'b0;
            rsp_rdata <= r_write ? 32'd0 : ((pci_rdata >> r_sh) & r_mask);
            st        <= S_RSP;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pci_win_xlat_chk.sv
module pci_win_xlat_chk #(
  parameter int IDSEL_LSB     = 13,
  parameter int CFG_SPAN_LOG2 = 20
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_addr,
  input logic        pci_valid,
  input logic        pci_ready,
  input logic [31:0] pci_addr,
  input logic [3:0]  pci_cmd,
  input logic [3:0]  pci_be,
  input logic [31:0] pci_wdata,
  input logic        rsp_valid,
  input logic        rsp_err,
  input logic [31:0] rsp_rdata
);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pci_valid && !pci_ready |=> pci_valid && $stable(pci_addr) && $stable(pci_cmd)
                                && $stable(pci_be) && $stable(pci_wdata));

  p_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pci_valid && pci_ready |=> !pci_valid);

  p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready);

  p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_addr[31:30] == 2'b10) |=> !req_ready);

  p_ignore_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_addr[31:30] != 2'b10) |=> req_ready && !pci_valid && !rsp_valid);

  p_idsel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pci_valid && pci_cmd[3] |-> ($countones(pci_addr[31:IDSEL_LSB]) == 1)
                                && ((pci_addr >> CFG_SPAN_LOG2) == 32'd0)
                                && (pci_addr[1:0] == 2'b00));

  p_be_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pci_valid |-> (pci_cmd[3] ? (pci_be == 4'hF) : (pci_be != 4'h0)));

  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_rdata == 32'hFFFF_FFFF);

endmodule

bind pci_win_xlat pci_win_xlat_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .pci_valid(pci_valid), .pci_ready(pci_ready),
  .pci_addr(pci_addr), .pci_cmd(pci_cmd), .pci_be(pci_be), .pci_wdata(pci_wdata),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
);

// File: tb/sim_pci_win_xlat.sv
`timescale 1ns/1ps
module sim_pci_win_xlat;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, cfg_mode = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [2:0]  req_size = 3'd4;
  logic [1:0]  mem_upper = 2'b00;
  logic        req_ready, pci_valid, rsp_valid, rsp_err;
  logic        pci_ready = 1'b0, pci_done = 1'b0, pci_abort = 1'b0;
  logic [31:0] pci_rdata = '0, pci_addr, pci_wdata, rsp_rdata;
  logic [3:0]  pci_cmd, pci_be;

  pci_win_xlat u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_size(req_size), .req_wdata(req_wdata),
    .cfg_mode(cfg_mode), .mem_upper(mem_upper), .pci_valid(pci_valid), .pci_ready(pci_ready),
    .pci_addr(pci_addr), .pci_cmd(pci_cmd), .pci_be(pci_be), .pci_wdata(pci_wdata),
    .pci_done(pci_done), .pci_abort(pci_abort), .pci_rdata(pci_rdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic [31:0] mem [logic [31:0]];
  function automatic logic [31:0] peek(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : {a[15:0] ^ 16'hA5C3, ~a[15:0]};
  endfunction

  int txn = 0, abort_at = -1, lat = 0;
  logic [31:0] lg_addr[$], lg_wd[$];
  logic [3:0]  lg_cmd[$], lg_be[$];

  initial begin : engine
    logic [31:0] a0, w0, bm, d;
    logic [3:0]  c0, b0;
    bit ab;
    forever begin
      @(negedge clk);
      if (pci_valid === 1'b1) begin
        a0 = pci_addr; w0 = pci_wdata; c0 = pci_cmd; b0 = pci_be;
        repeat (lat) begin
          @(negedge clk);
          check(pci_valid && pci_addr == a0 && pci_cmd == c0 && pci_be == b0 && pci_wdata == w0,
                "R10 hold", pci_addr, a0);
        end
        pci_ready = 1'b1;
        @(negedge clk);
        pci_ready = 1'b0;
        check(!pci_valid, "R10 drop", {31'd0, pci_valid}, 32'd0);
        ab = (txn == abort_at);
        txn++;
        bm = {{8{b0[3]}}, {8{b0[2]}}, {8{b0[1]}}, {8{b0[0]}}};
        d = peek(a0);
        if (!ab && c0[0]) mem[a0] = (d & ~bm) | (w0 & bm);
        lg_addr.push_back(a0); lg_wd.push_back(w0); lg_cmd.push_back(c0); lg_be.push_back(b0);
        pci_rdata = d; pci_abort = ab; pci_done = 1'b1;
        @(negedge clk);
        pci_done = 1'b0; pci_abort = 1'b0;
      end
    end
  end

  function automatic logic [31:0] lmask(input int sz);
    return (sz == 1) ? 32'hFF : (sz == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  task automatic clear_log();
    lg_addr.delete(); lg_wd.delete(); lg_cmd.delete(); lg_be.delete();
  endtask

  task automatic send(input logic [31:0] a, input bit w, input int sz, input logic [31:0] wd,
                      output bit got, output logic err, output logic [31:0] rd, output logic rdy_after);
    @(negedge clk);
    req_addr = a; req_write = w; req_size = 3'(sz); req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    rdy_after = req_ready;
    got = 1'b0; err = 1'b0; rd = '0;
    for (int i = 0; i < 40 && !got; i++) begin
      if (rsp_valid) begin got = 1'b1; err = rsp_err; rd = rsp_rdata; end
      else @(negedge clk);
    end
    if (got) begin
      @(negedge clk);
      check(req_ready && !rsp_valid, "R11 one-cycle response", {30'd0, req_ready, rsp_valid}, 32'd2);
    end
  endtask

  task automatic mem_op(input logic [31:0] a, input bit w, input int sz, input logic [31:0] wd,
                        input logic [1:0] up);
    bit got; logic err, ra; logic [31:0] rd, pa, pre, bm, exp_rd;
    logic [3:0] be;
    int sh;
    cfg_mode = 1'b0; mem_upper = up; clear_log();
    sh = 8 * int'(a[1:0]);
    pa = {up, a[29:2], 2'b00};
    pre = peek(pa);
    be = 4'(((sz == 1) ? 1 : (sz == 2) ? 3 : 15) << a[1:0]);
    bm = lmask(sz) << sh;
    send(a, w, sz, wd, got, err, rd, ra);
    check(got && !err, "R2 memory response", {31'd0, err}, 32'd0);
    check(ra == 1'b0, "R11 busy after accept", {31'd0, ra}, 32'd0);
    check(lg_addr.size() == 1, "R2 one bus request", lg_addr.size(), 32'd1);
    if (lg_addr.size() == 1) begin
      check(lg_addr[0] == pa, "R2 memory address", lg_addr[0], pa);
      check(lg_cmd[0] == (w ? 4'h7 : 4'h6), "R2 memory command", {28'd0, lg_cmd[0]}, w ? 32'd7 : 32'd6);
      check(lg_be[0] == be, "R6 byte enables", {28'd0, lg_be[0]}, {28'd0, be});
      if (w) check((lg_wd[0] & bm) == ((wd << sh) & bm), "R8 memory write lanes", lg_wd[0] & bm, (wd << sh) & bm);
    end
    exp_rd = w ? 32'd0 : ((pre >> sh) & lmask(sz));
    check(rd == exp_rd, "R7 read data", rd, exp_rd);
  endtask

  task automatic cfg_op(input int dev, input int fn, input int rg, input bit w, input int sz,
                        input logic [31:0] wd);
    bit got, bad; logic err, ra; logic [31:0] rd, a, pa, pre, m, exp_wd, exp_rd;
    longint full;
    int sh;
    cfg_mode = 1'b1; clear_log();
    a = {2'b10, 14'd0, 5'(dev), 3'(fn), 8'(rg)};
    full = (longint'(1) << (13 + dev)) | longint'(fn << 8) | longint'(rg & 'hFC);
    sh = 8 * (rg & 3);
    bad = (dev > 18) || (full >= 64'h10_0000) || (dev == 3) || ((rg & 3) + sz > 4);
    pa = full[31:0];
    pre = peek(pa);
    m = lmask(sz);
    send(a, w, sz, wd, got, err, rd, ra);
    if (bad) begin
      check(got && err && rd == 32'hFFFF_FFFF, "R5 rejected config request", rd, 32'hFFFF_FFFF);
      check(lg_addr.size() == 0, "R5 no bus request", lg_addr.size(), 32'd0);
    end else begin
      check(got && !err, "R3 config response", {31'd0, err}, 32'd0);
      check(lg_addr.size() == (w ? 2 : 1), "R8 phase count", lg_addr.size(), w ? 32'd2 : 32'd1);
      if (lg_addr.size() >= 1) begin
        check(lg_addr[0] == pa, "R4 config address", lg_addr[0], pa);
        check(lg_cmd[0] == 4'hA && lg_be[0] == 4'hF, "R3 config read command", {24'd0, lg_cmd[0], lg_be[0]}, 32'hAF);
      end
      if (w && lg_addr.size() == 2) begin
        exp_wd = (pre & ~(m << sh)) | ((wd & m) << sh);
        check(lg_cmd[1] == 4'hB && lg_addr[1] == pa, "R3 config write command", {28'd0, lg_cmd[1]}, 32'hB);
        check(lg_wd[1] == exp_wd, "R8 merged write data", lg_wd[1], exp_wd);
        check(peek(pa) == exp_wd, "R8 stored dword", peek(pa), exp_wd);
      end
      exp_rd = w ? 32'd0 : ((pre >> sh) & m);
      check(rd == exp_rd, "R7 config read data", rd, exp_rd);
    end
  endtask

  task automatic bad_size(input logic [31:0] a, input int sz);
    bit got; logic err, ra; logic [31:0] rd;
    cfg_mode = 1'b0; clear_log();
    send(a, 1'b0, sz, 32'd0, got, err, rd, ra);
    check(got && err && rd == 32'hFFFF_FFFF, "R6 illegal size or alignment", rd, 32'hFFFF_FFFF);
    check(lg_addr.size() == 0, "R6 no bus request", lg_addr.size(), 32'd0);
  endtask

  task automatic outside(input logic [31:0] a);
    bit got; logic err, ra; logic [31:0] rd;
    clear_log();
    send(a, 1'b1, 4, 32'h1234_5678, got, err, rd, ra);
    check(!got, "R1 no response outside window", {31'd0, got}, 32'd0);
    check(ra == 1'b1, "R1 ready stays high", {31'd0, ra}, 32'd1);
    check(lg_addr.size() == 0, "R1 no bus request", lg_addr.size(), 32'd0);
  endtask

  task automatic abort_case(input bit cfg, input bit w);
    bit got; logic err, ra; logic [31:0] rd, a;
    cfg_mode = cfg; clear_log();
    abort_at = txn;
    a = cfg ? {2'b10, 14'd0, 5'd1, 3'd0, 8'h08} : 32'hA000_0040;
    send(a, w, 4, 32'hDEAD_BEEF, got, err, rd, ra);
    check(got && err, "R9 abort reported", {31'd0, err}, 32'd1);
    check(rd == 32'hFFFF_FFFF, "R9 abort data", rd, 32'hFFFF_FFFF);
    check(lg_addr.size() == 1, "R9 no write phase after abort", lg_addr.size(), 32'd1);
    abort_at = -1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check(req_ready && !pci_valid && !rsp_valid, "R12 in reset", {29'd0, req_ready, pci_valid, rsp_valid}, 32'd4);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !pci_valid && !rsp_valid, "R12 after reset", {29'd0, req_ready, pci_valid, rsp_valid}, 32'd4);

    mem_op(32'h8000_0000, 1'b0, 4, 32'd0, 2'b00);
    mem_op(32'hBFFF_FFFC, 1'b1, 4, 32'h1122_3344, 2'b11);
    mem_op(32'hBFFF_FFFC, 1'b0, 4, 32'd0, 2'b11);
    mem_op(32'h9000_1233, 1'b1, 1, 32'h0000_00AB, 2'b01);
    mem_op(32'h9000_1230, 1'b0, 4, 32'd0, 2'b01);
    lat = 3;
    mem_op(32'h9000_1232, 1'b0, 2, 32'd0, 2'b10);
    mem_op(32'h9000_1231, 1'b0, 2, 32'd0, 2'b10);
    lat = 0;

    bad_size(32'h9000_0003, 2);
    bad_size(32'h9000_0000, 3);
    bad_size(32'h9000_0001, 4);
    bad_size(32'h9000_0000, 0);

    outside(32'h4000_0010);
    outside(32'hC000_0000);
    outside(32'h7FFF_FFFC);

    cfg_op(0, 2, 'h10, 1'b0, 4, 32'd0);
    cfg_op(6, 7, 'hFC, 1'b0, 4, 32'd0);
    cfg_op(1, 0, 'h0E, 1'b0, 1, 32'd0);
    lat = 2;
    cfg_op(2, 1, 'h06, 1'b1, 2, 32'hFFFF_BEEF);
    lat = 0;
    cfg_op(2, 1, 'h04, 1'b0, 4, 32'd0);
    cfg_op(4, 0, 'h41, 1'b1, 1, 32'h0000_005A);
    cfg_op(5, 3, 'h20, 1'b1, 4, 32'hCAFE_F00D);
    cfg_op(3, 0, 'h00, 1'b0, 4, 32'd0);
    cfg_op(7, 0, 'h00, 1'b0, 4, 32'd0);
    cfg_op(19, 0, 'h00, 1'b0, 4, 32'd0);
    cfg_op(31, 1, 'h08, 1'b1, 4, 32'd1);
    cfg_op(0, 0, 'h03, 1'b0, 2, 32'd0);

    abort_case(1'b1, 1'b0);
    abort_case(1'b1, 1'b1);
    abort_case(1'b0, 1'b1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule